// File: doc/BRIEF.md
# Link Bring-Up Sequencer

This block takes a root-port controller from reset to a usable link without any processor help. Once reset is released it runs a fixed script of read-modify-write edits on a small local control register file: it selects direct operating mode, sets root-complex mode, programs the transaction-layer options, selects Gen2 speed and a single lane, enables training and address-window mapping, and finally kicks link training. It then watches the link state field reported by the link core, polling it at a fixed interval for a bounded number of attempts.

When a poll finds the link state at or above the up threshold, the sequencer grants I/O, memory and bus-master access in the command register and signals success. If every attempt fails, it signals a timeout and leaves the command register untouched. Each register edit is also shown on a write strobe and target and data outputs, so the order of the script can be observed. A run restarts only on reset or on a `start` pulse.

Top module: `lbs_link_seq`

## Requirements
- R1: Synchronous active-high reset loads core_cfg=0x1, ctrl0=0x1A, ctrl2=0x0, link_ctl=0x0, cmd=0x0 and clears done and link_ok. The cycle after reset is released carries no write, and the first script write follows in the next cycle.
- R2: The script issues exactly one write per cycle, in this order, with wr_sel codes 0=core_cfg, 1=ctrl0, 2=ctrl2, 3=link_ctl, 4=cmd: clear core_cfg bit 0 (direct mode); set ctrl0 bit 2 (root-complex); write ctrl2 to 0x17 (reserved 0x7 plus bit 4, bit 5 strict ordering left 0); set the ctrl0 speed field [1:0] to 1 (Gen2; 0=Gen1, 2=Gen3); clear the ctrl0 lane field [4:3] to 0 (x1; 1=x2, 2=x4, 3=x8); set ctrl0 bit 6 (training enable); set ctrl2 bit 6 (window map enable); set link_ctl bit 5 (start training).
- R3: Each write is a read-modify-write of the current register value. wr_data is the new value, it appears in the selected register in the next cycle, and no register changes in a cycle without a write.
- R4: The link counts as up when ltssm_status[29:24] is at least LINK_UP_STATE (default 0x10). No other bit of ltssm_status has any effect.
- R5: The first poll takes place in the cycle after the training write. After a failed poll, POLL_GAP cycles pass before the next poll.
- R6: After POLL_LIMIT (default 10) failed polls, done pulses with link_ok=0 in the cycle after the last poll, and no write reaches cmd.
- R7: In the cycle after a successful poll, cmd bits 2:0 (I/O, memory, bus-master enable) are set by a read-modify-write. In the next cycle done pulses with link_ok=1.
- R8: done is a single-cycle pulse. busy is high from reset or start until the done cycle (inclusive) and low afterwards. link_ok holds its value until the next start or reset.
- R9: A start pulse in any cycle restarts the script at its first write in the next cycle and clears link_ok. The register contents are kept, and a write issued in the start cycle still lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, launches a run when released |
| start | input | 1 | Restart the bring-up script |
| ltssm_status | input | 32 | Link core status word, link state in bits 29:24 |
| wr_valid | output | 1 | A register edit is applied this cycle |
| wr_sel | output | 3 | Target register code of the edit |
| wr_data | output | 32 | New value written by the edit |
| core_cfg | output | 32 | Core configuration register (bit 0: command mode) |
| ctrl0 | output | 32 | Control register 0 (speed, root-complex, lanes, training enable) |
| ctrl2 | output | 32 | Control register 2 (transaction options, window map) |
| link_ctl | output | 32 | Link control register (bit 5 starts training) |
| cmd | output | 32 | Command register (bits 2:0 access enables) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| link_ok | output | 1 | Result of the last run: 1 link up, 0 timeout |

## Verification
A wrong step index or a corrupted step entry shows on wr_sel or wr_data in the same cycle, and in the target register one cycle later. A poll counter that is off by one moves the done pulse by a whole POLL_GAP+1 window, or grants the enables after too few polls, so a wrong retry or gap count is visible at the cycle of done. A mistake in the field extraction or the threshold compare shows up at the exact threshold value and when stray bits outside the state field are set. Both cases either grant cmd early or never grant it.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    localparam int WORD_W   = 32;
    localparam int NUM_REGS = 5;
    localparam int SEL_W    = 3;
    localparam int STEP_W   = 4;

    localparam logic [STEP_W-1:0] LAST_STEP   = 4'd7;
    localparam logic [STEP_W-1:0] ENABLE_STEP = 4'd8;

    typedef enum logic [SEL_W-1:0] {
        RS_CORECFG = 3'd0,
        RS_CTRL0   = 3'd1,
        RS_CTRL2   = 3'd2,
        RS_LINKCTL = 3'd3,
        RS_CMD     = 3'd4
    } reg_sel_e;

    typedef enum logic [2:0] {
        PH_LAUNCH,
        PH_STEP,
        PH_POLL,
        PH_WAIT,
        PH_ENABLE,
        PH_FINISH,
        PH_IDLE
    } phase_e;

    typedef struct packed {
        reg_sel_e            sel;
        logic [WORD_W-1:0]   clr;
        logic [WORD_W-1:0]   set;
    } edit_t;

    localparam logic [WORD_W-1:0] INIT_CORECFG = 32'h0000_0001;
    localparam logic [WORD_W-1:0] INIT_CTRL0   = 32'h0000_001A;

    function automatic logic [WORD_W-1:0] init_word(int idx);
        case (idx)
            0:       return INIT_CORECFG;
            1:       return INIT_CTRL0;
            default: return '0;
        endcase
    endfunction

    // Bring-up script; the enable edit sits behind the last script step.
    function automatic edit_t script_step(logic [STEP_W-1:0] idx);
        edit_t e;
        case (idx)
            4'd0:    e = '{RS_CORECFG, 32'h0000_0001, 32'h0000_0000};
            4'd1:    e = '{RS_CTRL0,   32'h0000_0000, 32'h0000_0004};
            4'd2:    e = '{RS_CTRL2,   32'hFFFF_FFFF, 32'h0000_0017};
            4'd3:    e = '{RS_CTRL0,   32'h0000_0003, 32'h0000_0001};
            4'd4:    e = '{RS_CTRL0,   32'h0000_0018, 32'h0000_0000};
            4'd5:    e = '{RS_CTRL0,   32'h0000_0000, 32'h0000_0040};
            4'd6:    e = '{RS_CTRL2,   32'h0000_0000, 32'h0000_0040};
            4'd7:    e = '{RS_LINKCTL, 32'h0000_0000, 32'h0000_0020};
            default: e = '{RS_CMD,     32'h0000_0000, 32'h0000_0007};
        endcase
        return e;
    endfunction

    function automatic logic [WORD_W-1:0] apply_edit(logic [WORD_W-1:0] cur, edit_t e);
        return (cur & ~e.clr) | e.set;
    endfunction

    function automatic logic link_is_up(logic [WORD_W-1:0] status, logic [5:0] thr);
        return status[29:24] >= thr;
    endfunction

endpackage

// File: rtl/lbs_regfile.sv
module lbs_regfile
    import lbs_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               we,
    input  reg_sel_e                           sel,
    input  logic [WORD_W-1:0]                  wdata,
    output logic [WORD_W-1:0]                  rdata,
    output logic [NUM_REGS-1:0][WORD_W-1:0]    words
);

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rst) begin
                words[i] <= init_word(i);
            end else if (we && int'(sel) == i) begin
                words[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (int'(sel) == i) begin
                rdata = words[i];
            end
        end
    end

endmodule

// File: rtl/lbs_poll_ctrl.sv
module lbs_poll_ctrl #(
    parameter int unsigned POLL_GAP   = 16,
    parameter int unsigned POLL_LIMIT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic miss,
    input  logic waiting,
    output logic gap_expired,
    output logic tries_spent
);

    localparam int GAP_W = $clog2(POLL_GAP + 1);
    localparam int TRY_W = $clog2(POLL_LIMIT + 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(POLL_GAP - 1);
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_LIMIT - 1);

    logic [GAP_W-1:0] gap_q;
    logic [TRY_W-1:0] try_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            gap_q <= '0;
            try_q <= '0;
        end else if (miss) begin
            gap_q <= GAP_LOAD;
            try_q <= try_q + 1'b1;
        end else if (waiting && gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    assign gap_expired = (gap_q == '0);
    assign tries_spent = (try_q == TRY_LAST);

endmodule

// File: rtl/lbs_edit_unit.sv
module lbs_edit_unit
    import lbs_pkg::*;
(
    input  phase_e              phase,
    input  logic [STEP_W-1:0]   step_idx,
    input  logic [WORD_W-1:0]   cur_word,
    output logic                we,
    output reg_sel_e            sel,
    output logic [WORD_W-1:0]   new_word
);

    edit_t e;

    always_comb begin
        e        = script_step((phase == PH_ENABLE) ? ENABLE_STEP : step_idx);
        we       = (phase == PH_STEP) || (phase == PH_ENABLE);
        sel      = e.sel;
        new_word = apply_edit(cur_word, e);
    end

endmodule

// File: rtl/lbs_link_seq.sv
module lbs_link_seq
    import lbs_pkg::*;
#(
    parameter int unsigned POLL_GAP      = 16,
    parameter int unsigned POLL_LIMIT    = 10,
    parameter logic [5:0]  LINK_UP_STATE = 6'h10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] ltssm_status,
    output logic        wr_valid,
    output logic [2:0]  wr_sel,
    output logic [31:0] wr_data,
    output logic [31:0] core_cfg,
    output logic [31:0] ctrl0,
    output logic [31:0] ctrl2,
    output logic [31:0] link_ctl,
    output logic [31:0] cmd,
    output logic        busy,
    output logic        done,
    output logic        link_ok
);

    phase_e                             phase_q;
    logic [STEP_W-1:0]                  step_q;
    logic                               ok_q;
    logic                               link_up;
    logic                               miss;
    logic                               gap_expired;
    logic                               tries_spent;
    logic                               edit_we;
    reg_sel_e                           edit_sel;
    logic [WORD_W-1:0]                  edit_word;
    logic [WORD_W-1:0]                  cur_word;
    logic [NUM_REGS-1:0][WORD_W-1:0]    words;

    assign link_up = link_is_up(ltssm_status, LINK_UP_STATE);
    assign miss    = (phase_q == PH_POLL) && !link_up;

    lbs_edit_unit u_edit (
        .phase    (phase_q),
        .step_idx (step_q),
        .cur_word (cur_word),
        .we       (edit_we),
        .sel      (edit_sel),
        .new_word (edit_word)
    );

    lbs_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (edit_we),
        .sel   (edit_sel),
        .wdata (edit_word),
        .rdata (cur_word),
        .words (words)
    );

    lbs_poll_ctrl #(
        .POLL_GAP   (POLL_GAP),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_poll (
        .clk         (clk),
        .rst         (rst),
        .clear       (phase_q == PH_STEP),
        .miss        (miss),
        .waiting     (phase_q == PH_WAIT),
        .gap_expired (gap_expired),
        .tries_spent (tries_spent)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_LAUNCH;
            step_q  <= '0;
            ok_q    <= 1'b0;
        end else if (start) begin
            phase_q <= PH_STEP;
            step_q  <= '0;
            ok_q    <= 1'b0;
        end else begin
            case (phase_q)
                PH_LAUNCH: begin
                    phase_q <= PH_STEP;
                    step_q  <= '0;
                end
                PH_STEP: begin
                    if (step_q == LAST_STEP) phase_q <= PH_POLL;
                    else                     step_q  <= step_q + 1'b1;
                end
                PH_POLL: begin
                    if (link_up)          phase_q <= PH_ENABLE;
                    else if (tries_spent) phase_q <= PH_FINISH;
                    else                  phase_q <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (gap_expired) phase_q <= PH_POLL;
                end
                PH_ENABLE: begin
                    phase_q <= PH_FINISH;
                    ok_q    <= 1'b1;
                end
                PH_FINISH: phase_q <= PH_IDLE;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    assign wr_valid = edit_we;
    assign wr_sel   = edit_sel;
    assign wr_data  = edit_word;
    assign core_cfg = words[0];
    assign ctrl0    = words[1];
    assign ctrl2    = words[2];
    assign link_ctl = words[3];
    assign cmd      = words[4];
    assign busy     = (phase_q != PH_IDLE);
    assign done     = (phase_q == PH_FINISH);
    assign link_ok  = ok_q;

endmodule

// File: rtl/lbs_link_seq_chk.sv
module lbs_link_seq_chk #(
    parameter logic [5:0] LINK_UP_STATE = 6'h10
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [31:0] ltssm_status,
    input logic        wr_valid,
    input logic [2:0]  wr_sel,
    input logic [31:0] wr_data,
    input logic [31:0] core_cfg,
    input logic [31:0] ctrl0,
    input logic [31:0] ctrl2,
    input logic [31:0] link_ctl,
    input logic [31:0] cmd,
    input logic        busy,
    input logic        done,
    input logic        link_ok
);

    logic [2:0]  prev_sel;
    logic [31:0] landed;

    always_ff @(posedge clk) prev_sel <= wr_sel;

    always_comb begin
        case (prev_sel)
            3'd0:    landed = core_cfg;
            3'd1:    landed = ctrl0;
            3'd2:    landed = ctrl2;
            3'd3:    landed = link_ctl;
            default: landed = cmd;
        endcase
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> landed == $past(wr_data)) else $error("write did not land"); // R3

    AST_QUIET_REGS: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> $stable({core_cfg, ctrl0, ctrl2, link_ctl, cmd})) else $error("register moved without write"); // R3

    AST_VALID_TARGET: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> wr_sel <= 3'd4) else $error("bad write target"); // R2

    AST_ENABLE_AFTER_UP: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_sel == 3'd4) |-> $past(ltssm_status[29:24]) >= LINK_UP_STATE) else $error("enable before link up"); // R4

    AST_PASS_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (done && link_ok) |-> cmd[2:0] == 3'b111) else $error("pass without enables"); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !wr_valid && !done) else $error("activity while idle"); // R8

    AST_START_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |=> wr_valid && wr_sel == 3'd0 && !link_ok) else $error("start did not restart"); // R9

endmodule

bind lbs_link_seq lbs_link_seq_chk #(.LINK_UP_STATE(LINK_UP_STATE)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .ltssm_status (ltssm_status),
    .wr_valid     (wr_valid),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .core_cfg     (core_cfg),
    .ctrl0        (ctrl0),
    .ctrl2        (ctrl2),
    .link_ctl     (link_ctl),
    .cmd          (cmd),
    .busy         (busy),
    .done         (done),
    .link_ok      (link_ok)
);

// File: tb/sim_lbs_link_seq.sv
module sim_lbs_link_seq;

    localparam int CLK_PERIOD = 10;
    localparam int GAP   = 16;
    localparam int LIMIT = 10;

    localparam int M_LAUNCH = 0, M_STEP = 1, M_POLL = 2, M_WAIT = 3,
                   M_ENABLE = 4, M_FINISH = 5, M_IDLE = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] lt = '0;

    logic        wr_valid, busy, done, link_ok;
    logic [2:0]  wr_sel;
    logic [31:0] wr_data, core_cfg, ctrl0, ctrl2, link_ctl, cmd;

    lbs_link_seq #(.POLL_GAP(GAP), .POLL_LIMIT(LIMIT), .LINK_UP_STATE(6'h10)) u0 (
        .clk(clk), .rst(rst), .start(start), .ltssm_status(lt),
        .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
        .core_cfg(core_cfg), .ctrl0(ctrl0), .ctrl2(ctrl2), .link_ctl(link_ctl), .cmd(cmd),
        .busy(busy), .done(done), .link_ok(link_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // behavioural reference state
    int          m_phase = M_LAUNCH;
    int          m_idx = 0, m_tries = 0, m_gap = 0;
    bit          m_ok = 0, m_live = 0;
    logic [31:0] m_reg [5];

    task automatic check(bit cond, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic m_edit(int idx, output int sel, output logic [31:0] clr, output logic [31:0] set);
        case (idx)
            0: begin sel = 0; clr = 32'h1;        set = 32'h0;  end
            1: begin sel = 1; clr = 32'h0;        set = 32'h4;  end
            2: begin sel = 2; clr = 32'hFFFFFFFF; set = 32'h17; end
            3: begin sel = 1; clr = 32'h3;        set = 32'h1;  end
            4: begin sel = 1; clr = 32'h18;       set = 32'h0;  end
            5: begin sel = 1; clr = 32'h0;        set = 32'h40; end
            6: begin sel = 2; clr = 32'h0;        set = 32'h40; end
            7: begin sel = 3; clr = 32'h0;        set = 32'h20; end
            default: begin sel = 4; clr = 32'h0;  set = 32'h7;  end
        endcase
    endtask

    task automatic cmp_cycle();
        logic [31:0] act [5];
        bit ev;
        int sel;
        logic [31:0] clr, set;
        act[0] = core_cfg; act[1] = ctrl0; act[2] = ctrl2; act[3] = link_ctl; act[4] = cmd;
        ev = (m_phase == M_STEP) || (m_phase == M_ENABLE);
        check(wr_valid == ev, "R2 write strobe", {31'b0, wr_valid}, {31'b0, ev});
        if (ev) begin
            m_edit((m_phase == M_ENABLE) ? 8 : m_idx, sel, clr, set);
            check(wr_sel == sel[2:0], "R2 write target", {29'b0, wr_sel}, sel);
            check(wr_data == ((m_reg[sel] & ~clr) | set), "R3 write data", wr_data, (m_reg[sel] & ~clr) | set);
        end
        check(done == (m_phase == M_FINISH), "R8 done pulse", {31'b0, done}, {31'b0, m_phase == M_FINISH});
        check(busy == (m_phase != M_IDLE), "R8 busy", {31'b0, busy}, {31'b0, m_phase != M_IDLE});
        check(link_ok == m_ok, "R8 link_ok hold", {31'b0, link_ok}, {31'b0, m_ok});
        for (int i = 0; i < 5; i++)
            check(act[i] === m_reg[i], "R3 register contents", act[i], m_reg[i]);
    endtask

    task automatic m_advance(bit r, bit s, logic [31:0] l);
        int sel;
        logic [31:0] clr, set;
        bit up;
        if (r) begin
            m_phase = M_LAUNCH; m_idx = 0; m_tries = 0; m_gap = 0; m_ok = 0; m_live = 1;
            m_reg[0] = 32'h1; m_reg[1] = 32'h1A; m_reg[2] = 0; m_reg[3] = 0; m_reg[4] = 0;
            return;
        end
        if (m_phase == M_STEP || m_phase == M_ENABLE) begin
            m_edit((m_phase == M_ENABLE) ? 8 : m_idx, sel, clr, set);
            m_reg[sel] = (m_reg[sel] & ~clr) | set;
        end
        if (s) begin
            m_phase = M_STEP; m_idx = 0; m_ok = 0;
            return;
        end
        up = ((l >> 24) & 32'h3F) >= 32'h10;
        case (m_phase)
            M_LAUNCH: begin m_phase = M_STEP; m_idx = 0; end
            M_STEP: begin
                if (m_idx == 7) begin m_phase = M_POLL; m_tries = 0; end
                else m_idx++;
            end
            M_POLL: begin
                if (up) m_phase = M_ENABLE;
                else begin
                    m_tries++;
                    if (m_tries == LIMIT) m_phase = M_FINISH;
                    else begin m_phase = M_WAIT; m_gap = GAP; end
                end
            end
            M_WAIT: begin
                m_gap--;
                if (m_gap == 0) m_phase = M_POLL;
            end
            M_ENABLE: begin m_phase = M_FINISH; m_ok = 1; end
            M_FINISH: m_phase = M_IDLE;
            default: ;
        endcase
    endtask

    task automatic tick(bit r, bit s, logic [31:0] l);
        @(negedge clk);
        rst = r; start = s; lt = l;
        #1;
        if (m_live && !finished) cmp_cycle();
        m_advance(r, s, l);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        int cnt;
        // reset and reset state (R1)
        for (int i = 0; i < 3; i++) tick(1, 0, 32'h0500_0000);
        tick(0, 0, 32'h0500_0000);
        check(core_cfg == 32'h1 && ctrl0 == 32'h1A && ctrl2 == 0 && link_ctl == 0 && cmd == 0,
              "R1 reset register values", ctrl0, 32'h1A);
        check(!done && !link_ok && !wr_valid, "R1 reset outputs quiet", {29'b0, done, link_ok, wr_valid}, 0);
        tick(0, 0, 32'h0500_0000);
        check(wr_valid && wr_sel == 3'd0, "R1 first write in second cycle", {29'b0, wr_sel}, 0);

        // pass on the third poll (R5, R7)
        for (int i = 0; i < 400 && m_tries < 2; i++) tick(0, 0, 32'h0500_0000);
        for (int i = 0; i < 400 && m_phase != M_IDLE; i++) tick(0, 0, 32'h3F00_0000);
        check(link_ok == 1'b1 && cmd == 32'h7, "R7 enables granted after up", cmd, 32'h7);
        check(ctrl0 == 32'h45, "R2 final ctrl0 fields", ctrl0, 32'h45);
        check(ctrl2 == 32'h57 && link_ctl == 32'h20 && core_cfg == 32'h0, "R2 final ctrl2", ctrl2, 32'h57);
        tick(0, 0, 32'h3F00_0000);
        check(link_ok == 1'b1 && !busy, "R8 link_ok held while idle", {31'b0, link_ok}, 1);

        // timeout just below threshold (R4, R5, R6)
        for (int i = 0; i < 3; i++) tick(1, 0, 32'h0F00_0000);
        cnt = 0;
        for (int i = 0; i < 1000; i++) begin
            tick(0, 0, 32'h0F00_0000);
            cnt++;
            if (done) break;
        end
        check(cnt == 11 + (LIMIT - 1) * (GAP + 1), "R6 timeout after last poll", cnt, 11 + (LIMIT - 1) * (GAP + 1));
        check(!link_ok && cmd == 32'h0, "R6 no enables on timeout", cmd, 0);

        // exact threshold passes on first poll (R4, R9)
        tick(0, 1, 32'h1000_0000);
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            tick(0, 0, 32'h1000_0000);
            cnt++;
            if (done) break;
        end
        check(cnt == 11 && link_ok, "R4 threshold 0x10 counts as up", cnt, 11);

        // stray bits outside the state field and restarts (R4, R9)
        tick(0, 0, 32'hC0FF_FFFF);
        tick(0, 1, 32'hC0FF_FFFF);
        tick(0, 0, 32'hC0FF_FFFF);
        check(wr_valid && wr_sel == 3'd0 && !link_ok, "R9 restart clears link_ok", {31'b0, link_ok}, 0);
        check(core_cfg == 32'h0 && cmd == 32'h7, "R9 registers kept on restart", cmd, 32'h7);
        for (int i = 0; i < 400 && m_tries < 3; i++) tick(0, 0, 32'hC0FF_FFFF);
        check(busy && !link_ok, "R4 bits outside 29:24 ignored", {31'b0, busy}, 1);
        tick(0, 1, 32'hC0FF_FFFF);
        tick(0, 0, 32'h2000_0000);
        check(wr_valid && wr_sel == 3'd0, "R9 restart from wait", {29'b0, wr_sel}, 0);
        for (int i = 0; i < 400 && m_phase != M_IDLE; i++) tick(0, 0, 32'h2000_0000);
        check(link_ok && cmd == 32'h7, "R7 pass after restart", {31'b0, link_ok}, 1);

        for (int i = 0; i < 3; i++) tick(0, 0, 32'h2000_0000);
        report();
    end

endmodule